// File: doc/BRIEF.md
# Ping-Pong Audio Capture DMA

This block takes 16-bit microphone samples, one per strobe, and stores each as a halfword write on a plain memory write port. It fills two destination buffers in turn. Software programs two 32-bit base addresses as low and high 16-bit halves, a record length in samples and a mode word. It then enables the channel and starts the engine with a two-write reset sequence. After each record of the programmed length the block flags end-of-process, which can drive an interrupt. With auto-load on, it moves straight to the other buffer.

In use, software drains one buffer while the engine fills the other. It acknowledges each completion by writing 1 to the status bit. If a second completion arrives before the first was acknowledged, a sticky overrun flag records the loss.

Top module: `pcap_dma`

## Requirements
- R1: Each sample strobe accepted while the engine runs produces exactly one write (mem_we high for one cycle) in the next cycle. That write carries the sample data.
- R2: Register map by reg_addr: 0/1 = low/high half of base A, 2/3 = low/high half of base B, 4 = record length, 5 = mode (bit0 auto-load, bit1 increment), 6 = status, 7 = interrupt enable (bit0), 8 = channel enable (bit0), 9 = sequence register (bit0). Each base address is the 32-bit concatenation {high, low}, and every register reads back on reg_rdata combinationally.
- R3: A record holds the programmed number of samples. A length of 0 acts as 1. The length resets to 1000.
- R4: With auto-load set, the sample after a record's last one goes to the other base at offset 0, with no idle cycle in between. Buffers alternate A, B, A, and so on.
- R5: With auto-load clear, the engine halts after a record completes. It ignores strobes until the next start sequence.
- R6: With increment set, sample k of a record is written to base + 2k. With increment clear, every sample is written to the base.
- R7: Status bit0 (end-of-process) sets when a record completes, and bit2 then shows which buffer completed (0 = A, 1 = B). Writing 1 to bit0 clears it, but a completion in the same cycle wins.
- R8: irq is high exactly while status bit0 and interrupt-enable bit0 are both 1.
- R9: While channel-enable bit0 is 0, strobes cause no writes. When the channel is re-enabled, the engine continues where it stopped.
- R10: Writing the sequence register with bit0 = 1 while its stored bit0 is 0 restarts the engine at base A, offset 0, and ends a halt. Writing 1 while the stored bit is already 1 has no effect.
- R11: Status bit1 (overrun) sets when a record completes while bit0 is still set. It stays set until a 1 is written to bit1.
- R12: After reset there are no writes and irq is low. All registers read 0 except the length, which reads 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Sample value |
| mem_we | output | 1 | Halfword write strobe |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 16 | Halfword write data |
| irq | output | 1 | End-of-process interrupt |

## Verification
The bench goes after the record boundary. A counter that is off by one would write one sample too many into a buffer, or start the next buffer at offset 2, and either fault shows up as a wrong mem_addr. It drives back-to-back strobes across a buffer switch, where an idle cycle or a missed toggle would write to the wrong base. It also drives a status clear in the same cycle as a completion, where a design that let the clear win would lose the interrupt. It checks that overrun is taken only from an unacknowledged completion, that a halted or disabled engine writes nothing, and that repeated start writes without the 0 write leave a running record untouched.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 32;
    localparam int RIDX_W = 4;
    localparam int NBUF   = 2;

    typedef enum logic [RIDX_W-1:0] {
        RG_A_LO  = 4'd0,
        RG_A_HI  = 4'd1,
        RG_B_LO  = 4'd2,
        RG_B_HI  = 4'd3,
        RG_LEN   = 4'd4,
        RG_MODE  = 4'd5,
        RG_STAT  = 4'd6,
        RG_IEN   = 4'd7,
        RG_CHEN  = 4'd8,
        RG_SEQ   = 4'd9
    } reg_idx_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base_a;
        logic [ADDR_W-1:0] base_b;
        logic [DATA_W-1:0] rec_len;
        logic              auto_ld;
        logic              incr;
        logic              chen;
    } eng_cfg_t;

    typedef struct packed {
        logic done;
        logic buf_id;
    } rec_evt_t;

    function automatic logic [RIDX_W-1:0] base_lo_idx(input int g);
        return RIDX_W'(2 * g);
    endfunction

    function automatic logic [ADDR_W-1:0] hw_offset(input logic [DATA_W-1:0] idx,
                                                    input logic incr);
        return incr ? {{(ADDR_W-DATA_W-1){1'b0}}, idx, 1'b0} : '0;
    endfunction

endpackage

// File: rtl/pcap_regs.sv
module pcap_regs
    import pcap_pkg::*;
#(
    parameter int DEFAULT_LEN = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  rec_evt_t          evt,
    output eng_cfg_t          cfg,
    output logic              restart,
    output logic              irq_o
);

    logic [ADDR_W-1:0] base_w [NBUF];
    logic [DATA_W-1:0] len_q;
    logic [1:0]        mode_q;
    logic              ien_q, chen_q, seq_q;
    logic              eop_q, ovr_q, last_buf_q;
    logic              stat_wr;

    for (genvar g = 0; g < NBUF; g++) begin : g_base
        logic [ADDR_W-1:0] base_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
            end else if (reg_we && reg_addr == base_lo_idx(g)) begin
                base_q[DATA_W-1:0] <= reg_wdata;
            end else if (reg_we && reg_addr == base_lo_idx(g) + 4'd1) begin
                base_q[ADDR_W-1:DATA_W] <= reg_wdata;
            end
        end
        assign base_w[g] = base_q;
    end

    assign stat_wr = reg_we && reg_addr == RG_STAT;
    assign restart = reg_we && reg_addr == RG_SEQ && reg_wdata[0] && !seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= DATA_W'(DEFAULT_LEN);
            mode_q     <= '0;
            ien_q      <= 1'b0;
            chen_q     <= 1'b0;
            seq_q      <= 1'b0;
            eop_q      <= 1'b0;
            ovr_q      <= 1'b0;
            last_buf_q <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    RG_LEN:  len_q  <= reg_wdata;
                    RG_MODE: mode_q <= reg_wdata[1:0];
                    RG_IEN:  ien_q  <= reg_wdata[0];
                    RG_CHEN: chen_q <= reg_wdata[0];
                    RG_SEQ:  seq_q  <= reg_wdata[0];
                    default: ;
                endcase
            end
            eop_q <= evt.done || (eop_q && !(stat_wr && reg_wdata[0]));
            ovr_q <= (evt.done && eop_q) || (ovr_q && !(stat_wr && reg_wdata[1]));
            if (evt.done) last_buf_q <= evt.buf_id;
        end
    end

    always_comb begin
        cfg.base_a  = base_w[0];
        cfg.base_b  = base_w[1];
        cfg.rec_len = len_q;
        cfg.auto_ld = mode_q[0];
        cfg.incr    = mode_q[1];
        cfg.chen    = chen_q;
    end

    assign irq_o = eop_q && ien_q;

    always_comb begin
        case (reg_addr)
            RG_A_LO: reg_rdata = base_w[0][DATA_W-1:0];
            RG_A_HI: reg_rdata = base_w[0][ADDR_W-1:DATA_W];
            RG_B_LO: reg_rdata = base_w[1][DATA_W-1:0];
            RG_B_HI: reg_rdata = base_w[1][ADDR_W-1:DATA_W];
            RG_LEN:  reg_rdata = len_q;
            RG_MODE: reg_rdata = {{(DATA_W-2){1'b0}}, mode_q};
            RG_STAT: reg_rdata = {{(DATA_W-3){1'b0}}, last_buf_q, ovr_q, eop_q};
            RG_IEN:  reg_rdata = {{(DATA_W-1){1'b0}}, ien_q};
            RG_CHEN: reg_rdata = {{(DATA_W-1){1'b0}}, chen_q};
            RG_SEQ:  reg_rdata = {{(DATA_W-1){1'b0}}, seq_q};
            default: reg_rdata = '0;
        endcase
    end

    // R7: a completion always leaves end-of-process set
    a_r7_done_sets_eop: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> eop_q);

    // R11: overrun only rises on top of an unacknowledged completion
    a_r11_ovr_needs_eop: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(eop_q));

endmodule

// File: rtl/pcap_engine.sv
module pcap_engine
    import pcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  eng_cfg_t          cfg,
    input  logic              restart,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output rec_evt_t          evt
);

    logic              cur_q;
    logic              halt_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] len_eff;
    logic              fire, last;
    logic [ADDR_W-1:0] base_sel;

    assign len_eff  = (cfg.rec_len == '0) ? DATA_W'(1) : cfg.rec_len;
    assign last     = ({1'b0, cnt_q} + 17'd1) >= {1'b0, len_eff};
    assign fire     = smp_valid && cfg.chen && !halt_q && !restart;
    assign base_sel = cur_q ? cfg.base_b : cfg.base_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= 1'b0;
            halt_q    <= 1'b0;
            cnt_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= fire;
            if (fire) begin
                mem_addr  <= base_sel + hw_offset(cnt_q, cfg.incr);
                mem_wdata <= smp_data;
            end
            if (restart) begin
                cur_q  <= 1'b0;
                cnt_q  <= '0;
                halt_q <= 1'b0;
            end else if (fire) begin
                if (last) begin
                    cnt_q  <= '0;
                    cur_q  <= !cur_q;
                    halt_q <= !cfg.auto_ld;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign evt.done   = fire && last;
    assign evt.buf_id = cur_q;

    // R1: every write is caused by a strobe one cycle earlier
    a_r1_write_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(smp_valid));

    // R5: a halted engine writes nothing unless restarted
    a_r5_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !restart) |=> !mem_we);

    // R4: a completed record under auto-load swaps buffer and restarts count
    a_r4_swap_on_done: assert property (@(posedge clk) disable iff (rst)
        (fire && last && cfg.auto_ld && !restart) |=> (cnt_q == '0 && cur_q != $past(cur_q)));

    // R9: disabled channel produces no write
    a_r9_chen_gates: assert property (@(posedge clk) disable iff (rst)
        !cfg.chen |=> !mem_we);

endmodule

// File: rtl/pcap_dma.sv
module pcap_dma
    import pcap_pkg::*;
#(
    parameter int DEFAULT_LEN = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        irq
);

    eng_cfg_t cfg;
    rec_evt_t evt;
    logic     restart;

    pcap_regs #(.DEFAULT_LEN(DEFAULT_LEN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .cfg       (cfg),
        .restart   (restart),
        .irq_o     (irq)
    );

    pcap_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .restart   (restart),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .evt       (evt)
    );

    // R8: interrupt never rises without a record completing in that cycle
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && !$past(reg_we)) |-> $past(evt.done));

endmodule

// File: tb/pcap_dma_bench.sv
`timescale 1ns/1ps
module pcap_dma_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        irq;

    always #2.5 clk = ~clk;

    pcap_dma u_pcap_dma (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    int n_cyc = 0;
    bit finished = 0;
    logic [3:0] rd_sel = 4'd6;

    // behavioural model state
    longint m_b0, m_b1;
    int     m_len, m_mode, m_ien, m_chen, m_seq;
    int     m_eop, m_ovr, m_lastb, m_cur, m_cnt, m_halt;
    int     m_we;
    longint m_addr;
    int     m_data;

    task automatic model_reset();
        m_b0 = 0; m_b1 = 0; m_len = 1000; m_mode = 0; m_ien = 0; m_chen = 0;
        m_seq = 0; m_eop = 0; m_ovr = 0; m_lastb = 0; m_cur = 0; m_cnt = 0;
        m_halt = 0; m_we = 0; m_addr = 0; m_data = 0;
    endtask

    task automatic model_step(input bit we, input int a, input int wd,
                              input bit sv, input int sd);
        bit rs, fire, done, clr;
        int leff, doneb;
        rs   = we && a == 9 && wd[0] && m_seq == 0;
        fire = sv && m_chen == 1 && m_halt == 0 && !rs;
        leff = (m_len == 0) ? 1 : m_len;
        done = fire && (m_cnt + 1 >= leff);
        doneb = m_cur;
        m_we = fire;
        if (fire) begin
            m_addr = ((m_cur == 1 ? m_b1 : m_b0) + ((m_mode & 2) != 0 ? 2 * m_cnt : 0)) & 64'hFFFF_FFFF;
            m_data = sd;
        end
        if (rs) begin
            m_cur = 0; m_cnt = 0; m_halt = 0;
        end else if (fire) begin
            if (done) begin
                m_cnt = 0; m_cur = 1 - m_cur; m_halt = ((m_mode & 1) == 0);
            end else m_cnt++;
        end
        clr = we && a == 6;
        begin
            int ne, no;
            ne = (done || (m_eop == 1 && !(clr && wd[0]))) ? 1 : 0;
            no = ((done && m_eop == 1) || (m_ovr == 1 && !(clr && wd[1]))) ? 1 : 0;
            m_eop = ne; m_ovr = no;
        end
        if (done) m_lastb = doneb;
        if (we) begin
            case (a)
                0: m_b0 = (m_b0 & 64'hFFFF_0000) | wd;
                1: m_b0 = (m_b0 & 64'h0000_FFFF) | (longint'(wd) << 16);
                2: m_b1 = (m_b1 & 64'hFFFF_0000) | wd;
                3: m_b1 = (m_b1 & 64'h0000_FFFF) | (longint'(wd) << 16);
                4: m_len = wd;
                5: m_mode = wd & 3;
                7: m_ien = wd & 1;
                8: m_chen = wd & 1;
                9: m_seq = wd & 1;
                default: ;
            endcase
        end
    endtask

    function automatic int model_rd(input int a);
        case (a)
            0: return int'(m_b0 & 16'hFFFF);
            1: return int'((m_b0 >> 16) & 16'hFFFF);
            2: return int'(m_b1 & 16'hFFFF);
            3: return int'((m_b1 >> 16) & 16'hFFFF);
            4: return m_len;
            5: return m_mode;
            6: return (m_lastb << 2) | (m_ovr << 1) | m_eop;
            7: return m_ien;
            8: return m_chen;
            9: return m_seq;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input string tag);
        int ra;
        ra = int'(reg_addr);
        n_vec++;
        if (mem_we !== 1'(m_we) || irq !== 1'(m_eop & m_ien) ||
            (m_we == 1 && (mem_addr !== 32'(m_addr) || mem_wdata !== 16'(m_data))) ||
            reg_rdata !== 16'(model_rd(ra))) begin
            n_bad++;
            $display("FAIL %s: got we=%0b addr=%h data=%h irq=%0b rd[%0d]=%h exp we=%0b addr=%h data=%h irq=%0b rd=%h",
                     tag, mem_we, mem_addr, mem_wdata, irq, ra, reg_rdata,
                     m_we, 32'(m_addr), 16'(m_data), m_eop & m_ien, 16'(model_rd(ra)));
        end
    endtask

    task automatic cyc(input bit we, input int a, input int wd, input bit sv,
                       input int sd, input string tag);
        reg_we    = we;
        reg_addr  = we ? 4'(a) : rd_sel;
        reg_wdata = 16'(wd);
        smp_valid = sv;
        smp_data  = 16'(sd);
        @(posedge clk);
        if (rst) model_reset(); else model_step(we, a, wd, sv, sd);
        #1;
        compare(tag);
    endtask

    task automatic wr(input int a, input int wd, input string tag);
        cyc(1, a, wd, 0, 0, tag);
    endtask

    task automatic smp(input int sd, input string tag);
        cyc(0, 0, 0, 1, sd, tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected under 50000", n_cyc);
            summary();
        end
    end

    initial begin
        model_reset();
        #1;
        repeat (3) idle("R12 reset");
        rst = 1'b0;
        rd_sel = 4'd4;
        idle("R12 length reset value");
        idle("R3 default 1000");
        rd_sel = 4'd6;
        idle("R12 status clear");

        wr(0, 16'h5000, "R2 base A low");
        wr(1, 16'h1234, "R2 base A high");
        wr(2, 16'h0800, "R2 base B low");
        wr(3, 16'hABCD, "R2 base B high");
        wr(4, 4, "R3 length");
        wr(5, 3, "R4 mode auto+incr");
        wr(7, 1, "R8 irq enable");
        wr(8, 1, "R9 channel on");
        wr(9, 0, "R10 seq zero");
        wr(9, 1, "R10 seq start");

        // record on A with gaps
        smp(16'h0100, "R1 first sample");
        idle("R1 gap");
        smp(16'h0101, "R6 increment");
        smp(16'h0102, "R1");
        idle("R1 gap");
        smp(16'h0103, "R7 eop on completion");
        idle("R8 irq high");
        // back-to-back on B, eop unacknowledged
        for (int i = 0; i < 4; i++) smp(16'h0200 + i, "R4 switch to B");
        idle("R11 overrun set");
        smp(16'h0300, "R4 back to A");
        smp(16'h0301, "R4 A offset");
        wr(6, 1, "R7 clear eop");
        idle("R11 overrun sticky");
        wr(6, 2, "R11 clear overrun");

        // channel disable
        wr(8, 0, "R9 channel off");
        for (int i = 0; i < 3; i++) smp(16'h0400 + i, "R9 ignored");
        wr(8, 1, "R9 channel on");
        smp(16'h0500, "R9 resumes");
        smp(16'h0501, "R7 completes A");
        wr(7, 0, "R8 mask off");
        idle("R8 irq low with eop");
        wr(7, 1, "R8 mask on");
        wr(6, 1, "R7 clear");

        // fixed address on B
        wr(5, 1, "R6 increment off");
        for (int i = 0; i < 4; i++) smp(16'h0600 + i, "R6 fixed address");
        wr(6, 1, "R7 clear");

        // no auto-load
        wr(5, 2, "R5 auto off");
        for (int i = 0; i < 4; i++) smp(16'h0700 + i, "R5 last record");
        for (int i = 0; i < 3; i++) smp(16'h0710 + i, "R5 halted ignores");
        wr(9, 1, "R10 repeat 1 no effect");
        smp(16'h0720, "R5 still halted");
        wr(9, 0, "R10 seq zero");
        wr(9, 1, "R10 restart");
        smp(16'h0800, "R10 base A offset 0");
        smp(16'h0801, "R10 continues");
        wr(9, 1, "R10 repeat mid-record");
        smp(16'h0802, "R10 no restart");
        wr(9, 0, "R10 seq zero");
        cyc(1, 9, 1, 1, 16'h0803, "R10 restart beats strobe");
        wr(5, 3, "R4 auto on");

        // length zero behaves as one, same-cycle clear vs completion
        wr(4, 0, "R3 length zero");
        smp(16'h0900, "R3 single-sample record");
        smp(16'h0901, "R3 single-sample record B");
        cyc(1, 6, 3, 1, 16'h0902, "R7 completion wins over clear");
        idle("R7 eop held");
        wr(6, 3, "R7 clear");
        smp(16'h0903, "R11 no overrun after ack");
        idle("R11");

        for (int a = 0; a < 12; a++) begin
            rd_sel = 4'(a);
            idle("R2 readback");
        end

        summary();
    end

endmodule